// File: doc/BRIEF.md
# Series Cell Voltage Protection Controller

This block is the digital decision core of a protector for a pack of four to seven cells in series. Analog comparators outside it produce per-cell flags. They report whether each cell is above the overcharge trip, below the overcharge recovery level, below the overdischarge trip, above the overdischarge recovery level, and below a deep low-voltage level. Two pack-level flags report whether a charger and a load are attached. The controller turns these into a charge-enable output and a discharge-enable output, which drive the external MOSFET gate drivers.

Every condition is qualified by a delay timer that counts ticks of a 1 ms timebase. The overcharge entry timer ignores brief dips below the trip level. A dip resets the timer only when it lasts long enough. How each protection is released depends on whether a charger is attached. After the pack has stayed overdischarged for a long time, the controller enters a low-power state and reports it on a sleep output. An optional low-voltage charge inhibit blocks charging of deeply depleted cells. Inputs from channels above the configured cell count are ignored.

Top module: `cell_guard_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `chg_en` = 1, `dsg_en` = 1 and `sleep_o` = 0, with all timers cleared.
- R2: When any active cell has `ov_hi` set for T_OC consecutive ticks, `chg_en` goes to 0 on the clock edge that takes the T_OC-th tick.
- R3: During overcharge qualification, a gap in the overcharge condition that is shorter than T_RESET ticks pauses the count without clearing it. A gap that lasts T_RESET ticks clears the count.
- R4: In overcharge protection, when every active cell has `ocr_lo` set for T_OCR consecutive ticks, `chg_en` returns to 1.
- R5: In overcharge protection with `chg_present` = 0, having no active cell with `ov_hi` set for T_OCR ticks also releases it. With `chg_present` = 1, that condition alone does not.
- R6: When any active cell has `ud_lo` set for T_OD consecutive ticks, `dsg_en` goes to 0.
- R7: In overdischarge protection with `chg_present` = 0, `dsg_en` returns to 1 only after every active cell has `udr_hi` set and `load_present` = 0 for T_ODR consecutive ticks.
- R8: In overdischarge protection with `chg_present` = 1, having no active cell with `ud_lo` set for T_ODR consecutive ticks releases it, whatever the state of `udr_hi`.
- R9: After T_SLP ticks in overdischarge protection, `sleep_o` becomes 1. While it is set, `dsg_en` = 0 and `chg_en` follows `chg_present` with one edge of delay. It clears on the edge that releases overdischarge.
- R10: With LV_INHIBIT_EN = 1, any active cell with `lv_lo` set forces `chg_en` to 0 on the next edge.
- R11: `cell_sel` values 0, 1, 2 and 3 select 4, 5, 6 and 7 cells. Bit i of each cell flag bus is the cell at position i, and bits at or above the selected count have no effect on any output.
- R12: Timers advance only on clock edges where `tick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 1 ms timebase period |
| cell_sel | input | 2 | Series cell count select, count = value + 4 |
| ov_hi | input | 7 | Per cell: above overcharge trip |
| ocr_lo | input | 7 | Per cell: below overcharge recovery level |
| ud_lo | input | 7 | Per cell: below overdischarge trip |
| udr_hi | input | 7 | Per cell: above overdischarge recovery level |
| lv_lo | input | 7 | Per cell: below low-voltage charge inhibit level |
| chg_present | input | 1 | Charger attached |
| load_present | input | 1 | Load attached |
| chg_en | output | 1 | Charge FET enable, registered |
| dsg_en | output | 1 | Discharge FET enable, registered |
| sleep_o | output | 1 | Low-power state indication |

## Verification
Overcharge entry and overdischarge entry can expire on the same clock edge. The bench provokes this by raising an overcharge flag on one cell and, two ticks later, an overdischarge flag on another. The two timers then reach their limits together, and both enables are checked to drop on that one edge. Sleep entry while the charger flag toggles is also exercised, because the output has to combine the state change with the charger input sampled on the same edge. A behavioural model built from integer counters predicts all three outputs and is compared with the block on every clock. Hand-computed checks at the timer boundaries back up the model.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  // Pack-level summary of the masked per-cell comparator flags
  typedef struct packed {
    logic any_ov;   // some active cell above overcharge trip
    logic all_ocr;  // every active cell below overcharge recovery
    logic any_ud;   // some active cell below overdischarge trip
    logic all_udr;  // every active cell above overdischarge recovery
    logic any_lv;   // some active cell below low-voltage inhibit
  } cell_sum_t;

endpackage

// File: rtl/cgc_delay_timer.sv
module cgc_delay_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic expire
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expire = run && tick && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run && tick) begin
      cnt_d = expire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cgc_cell_agg.sv
module cgc_cell_agg
  import cgc_pkg::*;
#(
  parameter int unsigned MAX_CELLS = 7,
  parameter int unsigned MIN_CELLS = 4,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [SEL_W-1:0]     cell_sel,
  input  logic [MAX_CELLS-1:0] ov_hi,
  input  logic [MAX_CELLS-1:0] ocr_lo,
  input  logic [MAX_CELLS-1:0] ud_lo,
  input  logic [MAX_CELLS-1:0] udr_hi,
  input  logic [MAX_CELLS-1:0] lv_lo,
  output cell_sum_t            sum
);

  logic [MAX_CELLS-1:0] active;

  // Position i is in use when it lies below the selected series count
  for (genvar i = 0; i < MAX_CELLS; i++) begin : g_mask
    if (i < MIN_CELLS) begin : g_fixed
      assign active[i] = 1'b1;
    end else begin : g_sel
      assign active[i] = (int'(cell_sel) + int'(MIN_CELLS)) > i;
    end
  end

  always_comb begin
    sum.any_ov  = |(ov_hi & active);
    sum.all_ocr = &(ocr_lo | ~active);
    sum.any_ud  = |(ud_lo & active);
    sum.all_udr = &(udr_hi | ~active);
    sum.any_lv  = |(lv_lo & active);
  end

endmodule

// File: rtl/cgc_ovc_ctrl.sv
module cgc_ovc_ctrl #(
  parameter int unsigned T_OC    = 1000,
  parameter int unsigned T_RESET = 4,
  parameter int unsigned T_OCR   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic any_ov,
  input  logic all_ocr,
  input  logic chg_present,
  output logic oc_q,
  output logic oc_nxt
);

  logic set_exp, dip_exp, rel_exp;
  logic set_run, set_clr, dip_run, dip_clr, rel_cond, rel_run;

  // Entry count pauses during a gap and clears only after a long gap
  assign set_run = any_ov && !oc_q;
  assign set_clr = oc_q || dip_exp;
  assign dip_run = !any_ov && !oc_q;
  assign dip_clr = any_ov || oc_q;

  // Recovery: all below recovery level, or no charger and none above trip
  assign rel_cond = all_ocr || (!chg_present && !any_ov);
  assign rel_run  = rel_cond && oc_q;

  cgc_delay_timer #(.LIMIT(T_OC)) u_set (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(set_run), .clr(set_clr), .expire(set_exp)
  );

  cgc_delay_timer #(.LIMIT(T_RESET)) u_dip (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(dip_run), .clr(dip_clr), .expire(dip_exp)
  );

  cgc_delay_timer #(.LIMIT(T_OCR)) u_rel (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(rel_run), .clr(!rel_run), .expire(rel_exp)
  );

  always_comb begin
    if (oc_q) begin
      oc_nxt = !rel_exp;
    end else begin
      oc_nxt = set_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
    end else begin
      oc_q <= oc_nxt;
    end
  end

endmodule

// File: rtl/cgc_ovd_ctrl.sv
module cgc_ovd_ctrl #(
  parameter int unsigned T_OD  = 1000,
  parameter int unsigned T_ODR = 240,
  parameter int unsigned T_SLP = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic any_ud,
  input  logic all_udr,
  input  logic chg_present,
  input  logic load_present,
  output logic od_q,
  output logic od_nxt,
  output logic slp_q,
  output logic slp_nxt
);

  logic set_exp, rel_exp, slp_exp;
  logic set_run, rel_cond, rel_run, slp_run, slp_clr;

  assign set_run = any_ud && !od_q;

  // With a charger only the trip level matters; without one, the recovery
  // level and an absent load are both needed
  assign rel_cond = chg_present ? !any_ud : (all_udr && !load_present);
  assign rel_run  = rel_cond && od_q;

  assign slp_run = od_q && !slp_q;
  assign slp_clr = !od_q || slp_q;

  cgc_delay_timer #(.LIMIT(T_OD)) u_set (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(set_run), .clr(!set_run), .expire(set_exp)
  );

  cgc_delay_timer #(.LIMIT(T_ODR)) u_rel (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(rel_run), .clr(!rel_run), .expire(rel_exp)
  );

  cgc_delay_timer #(.LIMIT(T_SLP)) u_slp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(slp_run), .clr(slp_clr), .expire(slp_exp)
  );

  always_comb begin
    if (od_q) begin
      od_nxt = !rel_exp;
    end else begin
      od_nxt = set_exp;
    end
    slp_nxt = od_nxt && (slp_q || slp_exp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q  <= 1'b0;
      slp_q <= 1'b0;
    end else begin
      od_q  <= od_nxt;
      slp_q <= slp_nxt;
    end
  end

endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl
  import cgc_pkg::*;
#(
  parameter int unsigned MAX_CELLS     = 7,
  parameter int unsigned MIN_CELLS     = 4,
  parameter int unsigned T_OC          = 1000,
  parameter int unsigned T_RESET       = 4,
  parameter int unsigned T_OCR         = 100,
  parameter int unsigned T_OD          = 1000,
  parameter int unsigned T_ODR         = 240,
  parameter int unsigned T_SLP         = 240000,
  parameter bit          LV_INHIBIT_EN = 1'b1,
  localparam int unsigned SEL_W =
    (MAX_CELLS - MIN_CELLS + 1 > 1) ? $clog2(MAX_CELLS - MIN_CELLS + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [SEL_W-1:0]     cell_sel,
  input  logic [MAX_CELLS-1:0] ov_hi,
  input  logic [MAX_CELLS-1:0] ocr_lo,
  input  logic [MAX_CELLS-1:0] ud_lo,
  input  logic [MAX_CELLS-1:0] udr_hi,
  input  logic [MAX_CELLS-1:0] lv_lo,
  input  logic                 chg_present,
  input  logic                 load_present,
  output logic                 chg_en,
  output logic                 dsg_en,
  output logic                 sleep_o
);

  cell_sum_t sum;
  logic oc_q, oc_nxt, od_q, od_nxt, slp_q, slp_nxt;
  logic lv_block;
  logic chg_en_d, dsg_en_d;

  cgc_cell_agg #(
    .MAX_CELLS(MAX_CELLS), .MIN_CELLS(MIN_CELLS), .SEL_W(SEL_W)
  ) u_agg (
    .cell_sel(cell_sel), .ov_hi(ov_hi), .ocr_lo(ocr_lo),
    .ud_lo(ud_lo), .udr_hi(udr_hi), .lv_lo(lv_lo), .sum(sum)
  );

  cgc_ovc_ctrl #(
    .T_OC(T_OC), .T_RESET(T_RESET), .T_OCR(T_OCR)
  ) u_ovc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .any_ov(sum.any_ov), .all_ocr(sum.all_ocr), .chg_present(chg_present),
    .oc_q(oc_q), .oc_nxt(oc_nxt)
  );

  cgc_ovd_ctrl #(
    .T_OD(T_OD), .T_ODR(T_ODR), .T_SLP(T_SLP)
  ) u_ovd (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .any_ud(sum.any_ud), .all_udr(sum.all_udr),
    .chg_present(chg_present), .load_present(load_present),
    .od_q(od_q), .od_nxt(od_nxt), .slp_q(slp_q), .slp_nxt(slp_nxt)
  );

  if (LV_INHIBIT_EN) begin : g_lv
    assign lv_block = sum.any_lv;
  end else begin : g_no_lv
    assign lv_block = 1'b0;
  end

  always_comb begin
    chg_en_d = !oc_nxt && !lv_block && !(slp_nxt && !chg_present);
    dsg_en_d = !od_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_en <= 1'b1;
      dsg_en <= 1'b1;
    end else begin
      chg_en <= chg_en_d;
      dsg_en <= dsg_en_d;
    end
  end

  assign sleep_o = slp_q;

endmodule

// File: rtl/cgc_chk.sv
module cgc_chk #(
  parameter int unsigned MAX_CELLS     = 7,
  parameter bit          LV_INHIBIT_EN = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [MAX_CELLS-1:0] ov_hi,
  input logic [MAX_CELLS-1:0] ud_lo,
  input logic [MAX_CELLS-1:0] lv_lo,
  input logic                 chg_present,
  input logic                 chg_en,
  input logic                 dsg_en,
  input logic                 sleep_o
);

  // R9
  sleep_blocks_dsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !dsg_en);

  // R9
  sleep_chg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && chg_en) |-> $past(chg_present));

  // R9
  sleep_exit_dsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> dsg_en);

  // R6
  od_entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsg_en) |-> $past(|ud_lo));

  // R2
  chg_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_en) |-> ($past(|ov_hi) || $past(|lv_lo) || !$past(chg_present)));

  // R10
  lv_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LV_INHIBIT_EN && $past(|lv_lo[3:0])) |-> !chg_en);

endmodule

bind cell_guard_ctrl cgc_chk #(
  .MAX_CELLS(MAX_CELLS), .LV_INHIBIT_EN(LV_INHIBIT_EN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ov_hi(ov_hi), .ud_lo(ud_lo), .lv_lo(lv_lo),
  .chg_present(chg_present), .chg_en(chg_en), .dsg_en(dsg_en),
  .sleep_o(sleep_o)
);

// File: tb/cell_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module cell_guard_ctrl_tb_top;

  localparam int T_OC = 12, T_RESET = 3, T_OCR = 5;
  localparam int T_OD = 10, T_ODR = 6, T_SLP = 30;

  logic clk = 1'b0;
  logic rst_n, tick;
  logic [1:0] cell_sel;
  logic [6:0] ov_hi, ocr_lo, ud_lo, udr_hi, lv_lo;
  logic chg_present, load_present;
  logic chg_en, dsg_en, sleep_o;

  int n_checks = 0, n_fail = 0;
  int tdiv = 1, tcnt = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cell_guard_ctrl #(
    .T_OC(T_OC), .T_RESET(T_RESET), .T_OCR(T_OCR),
    .T_OD(T_OD), .T_ODR(T_ODR), .T_SLP(T_SLP), .LV_INHIBIT_EN(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cell_sel(cell_sel),
    .ov_hi(ov_hi), .ocr_lo(ocr_lo), .ud_lo(ud_lo), .udr_hi(udr_hi),
    .lv_lo(lv_lo), .chg_present(chg_present), .load_present(load_present),
    .chg_en(chg_en), .dsg_en(dsg_en), .sleep_o(sleep_o)
  );

  // Behavioural reference: plain integer counters per qualified condition
  int m_occ, m_dip, m_ocr, m_odc, m_odr, m_slc;
  bit m_oc, m_od, m_sl, m_chg, m_dsg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_occ = 0; m_dip = 0; m_ocr = 0; m_odc = 0; m_odr = 0; m_slc = 0;
      m_oc = 0; m_od = 0; m_sl = 0; m_chg = 1; m_dsg = 1;
    end else begin
      int ncell;
      bit aov, aocr, aud, audr, alv, rel, n_oc, n_od, n_sl;
      ncell = int'(cell_sel) + 4;
      aov = 0; aocr = 1; aud = 0; audr = 1; alv = 0;
      for (int i = 0; i < ncell; i++) begin
        if (ov_hi[i]) aov = 1;
        if (!ocr_lo[i]) aocr = 0;
        if (ud_lo[i]) aud = 1;
        if (!udr_hi[i]) audr = 0;
        if (lv_lo[i]) alv = 1;
      end
      n_oc = m_oc;
      if (!m_oc) begin
        m_ocr = 0;
        if (aov) begin
          m_dip = 0;
          if (tick) begin
            if (m_occ == T_OC - 1) begin n_oc = 1; m_occ = 0; end
            else m_occ++;
          end
        end else if (tick) begin
          if (m_dip == T_RESET - 1) begin m_dip = 0; m_occ = 0; end
          else m_dip++;
        end
      end else begin
        m_occ = 0; m_dip = 0;
        rel = aocr || (!chg_present && !aov);
        if (!rel) m_ocr = 0;
        else if (tick) begin
          if (m_ocr == T_OCR - 1) begin n_oc = 0; m_ocr = 0; end
          else m_ocr++;
        end
      end
      n_od = m_od;
      n_sl = m_sl;
      if (!m_od) begin
        m_odr = 0; m_slc = 0;
        if (!aud) m_odc = 0;
        else if (tick) begin
          if (m_odc == T_OD - 1) begin n_od = 1; m_odc = 0; end
          else m_odc++;
        end
      end else begin
        m_odc = 0;
        rel = chg_present ? !aud : (audr && !load_present);
        if (!rel) m_odr = 0;
        else if (tick) begin
          if (m_odr == T_ODR - 1) begin n_od = 0; m_odr = 0; end
          else m_odr++;
        end
        if (m_sl) m_slc = 0;
        else if (tick) begin
          if (m_slc == T_SLP - 1) begin n_sl = 1; m_slc = 0; end
          else m_slc++;
        end
      end
      n_sl = n_od && n_sl;
      m_oc = n_oc; m_od = n_od; m_sl = n_sl;
      m_dsg = !n_od;
      m_chg = !n_oc && !alv && !(n_sl && !chg_present);
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (chg_en !== m_chg || dsg_en !== m_dsg || sleep_o !== m_sl) begin
        n_fail++;
        $display("FAIL %s model: got chg=%0b dsg=%0b slp=%0b exp chg=%0b dsg=%0b slp=%0b",
                 cur_req, chg_en, dsg_en, sleep_o, m_chg, m_dsg, m_sl);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      tcnt++;
      tick = ((tcnt % tdiv) == 0);
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; tick = 1; cell_sel = 2'd3;
    ov_hi = '0; ocr_lo = 7'h7F; ud_lo = '0; udr_hi = 7'h7F; lv_lo = '0;
    chg_present = 1; load_present = 0;
    repeat (3) @(negedge clk);
    chk("R1", "chg_en in reset", chg_en, 1'b1);
    chk("R1", "dsg_en in reset", dsg_en, 1'b1);
    rst_n = 1;
    step(2);
    chk("R1", "sleep_o after reset", sleep_o, 1'b0);

    // R2 entry
    cur_req = "R2";
    ov_hi[2] = 1; ocr_lo[2] = 0;
    step(T_OC - 1); chk("R2", "chg before T_OC", chg_en, 1'b1);
    step(1);        chk("R2", "chg at T_OC", chg_en, 1'b0);

    // R4 release by recovery level
    cur_req = "R4";
    ov_hi = '0; ocr_lo = 7'h7F;
    step(T_OCR - 1); chk("R4", "chg before T_OCR", chg_en, 1'b0);
    step(1);         chk("R4", "chg at T_OCR", chg_en, 1'b1);

    // R3 short gap pauses the count
    cur_req = "R3";
    ov_hi[2] = 1; ocr_lo[2] = 0; step(8);
    ov_hi[2] = 0; step(T_RESET - 1);
    ov_hi[2] = 1; step(T_OC - 8 - 1);
    chk("R3", "short gap, one tick left", chg_en, 1'b1);
    step(1); chk("R3", "short gap, count kept", chg_en, 1'b0);
    ov_hi = '0; ocr_lo = 7'h7F; step(T_OCR);
    chk("R4", "released again", chg_en, 1'b1);
    // R3 long gap clears the count
    ov_hi[2] = 1; ocr_lo[2] = 0; step(8);
    ov_hi[2] = 0; step(T_RESET);
    ov_hi[2] = 1; step(T_OC - 1);
    chk("R3", "long gap restarted count", chg_en, 1'b1);
    step(1); chk("R3", "full T_OC after long gap", chg_en, 1'b0);

    // R5 charger-absent release
    cur_req = "R5";
    ov_hi = '0;
    step(T_OCR + 2); chk("R5", "charger present, no release", chg_en, 1'b0);
    chg_present = 0;
    step(T_OCR - 1); chk("R5", "no charger, before T_OCR", chg_en, 1'b0);
    step(1);         chk("R5", "no charger release", chg_en, 1'b1);
    ocr_lo = 7'h7F; chg_present = 1;

    // R10 low-voltage inhibit
    cur_req = "R10";
    lv_lo[1] = 1; step(1); chk("R10", "inhibit on", chg_en, 1'b0);
    lv_lo[1] = 0; step(1); chk("R10", "inhibit off", chg_en, 1'b1);

    // R11 masking of unused cells
    cur_req = "R11";
    cell_sel = 2'd0; ov_hi[6] = 1; ud_lo[5] = 1; lv_lo[4] = 1;
    step(T_OC + T_OD);
    chk("R11", "masked cells chg", chg_en, 1'b1);
    chk("R11", "masked cells dsg", dsg_en, 1'b1);
    ov_hi = '0; ud_lo = '0; lv_lo = '0;
    cell_sel = 2'd1; ov_hi[4] = 1;
    step(T_OC); chk("R11", "fifth cell active", chg_en, 1'b0);
    ov_hi = '0; step(T_OCR); chk("R11", "fifth cell release", chg_en, 1'b1);
    cell_sel = 2'd3;

    // R6 overdischarge entry
    cur_req = "R6";
    ud_lo[0] = 1; udr_hi[0] = 0;
    step(T_OD - 1); chk("R6", "dsg before T_OD", dsg_en, 1'b1);
    step(1);        chk("R6", "dsg at T_OD", dsg_en, 1'b0);

    // R7 no-charger release needs no load
    cur_req = "R7";
    chg_present = 0; ud_lo = '0; udr_hi = 7'h7F; load_present = 1;
    step(T_ODR + 2); chk("R7", "load blocks release", dsg_en, 1'b0);
    load_present = 0;
    step(T_ODR - 1); chk("R7", "before T_ODR", dsg_en, 1'b0);
    step(1);         chk("R7", "release", dsg_en, 1'b1);

    // R8 charger release at trip level
    cur_req = "R8";
    ud_lo[0] = 1; udr_hi[0] = 0; step(T_OD);
    chk("R8", "re-entry", dsg_en, 1'b0);
    chg_present = 1; ud_lo = '0;
    step(T_ODR - 1); chk("R8", "before T_ODR", dsg_en, 1'b0);
    step(1);         chk("R8", "charger release", dsg_en, 1'b1);

    // R9 low-power state
    cur_req = "R9";
    chg_present = 0; ud_lo[0] = 1; step(T_OD);
    chk("R9", "od entered", dsg_en, 1'b0);
    step(T_SLP - 1); chk("R9", "sleep before T_SLP", sleep_o, 1'b0);
    step(1);         chk("R9", "sleep at T_SLP", sleep_o, 1'b1);
    chk("R9", "chg low asleep, no charger", chg_en, 1'b0);
    chg_present = 1; step(1); chk("R9", "chg high asleep with charger", chg_en, 1'b1);
    chg_present = 0; step(1); chk("R9", "chg low again", chg_en, 1'b0);
    chg_present = 1; ud_lo = '0; udr_hi = 7'h7F;
    step(T_ODR); chk("R9", "sleep cleared", sleep_o, 1'b0);
    chk("R9", "dsg after wake", dsg_en, 1'b1);

    // Coincident overcharge and overdischarge entry
    cur_req = "R2/R6";
    ov_hi[3] = 1; ocr_lo[3] = 0; step(2);
    ud_lo[0] = 1; udr_hi[0] = 0; step(T_OD - 1);
    chk("R2", "coincident, chg one before", chg_en, 1'b1);
    chk("R6", "coincident, dsg one before", dsg_en, 1'b1);
    step(1);
    chk("R2", "coincident chg", chg_en, 1'b0);
    chk("R6", "coincident dsg", dsg_en, 1'b0);
    ov_hi = '0; ocr_lo = 7'h7F; ud_lo = '0; udr_hi = 7'h7F;
    step(T_ODR);
    chk("R4", "coincident chg release", chg_en, 1'b1);
    chk("R8", "coincident dsg release", dsg_en, 1'b1);

    // R12 slow timebase
    cur_req = "R12";
    tdiv = 3; ud_lo[0] = 1; udr_hi[0] = 0;
    step(T_OD); chk("R12", "sparse ticks delay entry", dsg_en, 1'b1);
    step(3 * T_OD); chk("R12", "entry after T_OD ticks", dsg_en, 1'b0);
    ud_lo = '0; udr_hi = 7'h7F;
    step(3 * T_ODR + 3); chk("R12", "release with sparse ticks", dsg_en, 1'b1);
    tdiv = 1; step(4);

    finish_run();
  end

endmodule